// File: doc/BRIEF.md
# Power-Fail Guarded Byte Memory

This block is a 2048-byte, byte-wide memory driven by three active-low control pins (select, write strobe, output enable), an 11-bit address and an 8-bit data bus. The pins are treated as if they came from an asynchronous host. The block passes them through two-stage synchronisers and then finds their edges on a single internal clock. A write is framed by the overlap of select and write strobe. It is committed when that overlap ends, and it is followed by a recovery interval that is enforced. Any write attempted during that interval is dropped and recorded in a sticky error flag.

An external supply monitor drives two digital inputs. The first is a power-fail flag, which freezes the memory at once: writes are blocked, a write window that is still open is discarded, every pin is ignored and the bus drivers are switched off. The second is a supply-good flag, and only this flag lets the block leave protection. Dropping power-fail on its own does not. Reset does not touch the stored bytes, so the contents outlive both protection episodes and resets. Reset puts the block into active mode.

The data bus is split into an input lane, an output lane and a drive-enable. A pad ring joins them into a bidirectional bus.

Top module: `nvSramGuard`

## Requirements
- R1: The array holds 2048 bytes addressed by `addr[10:0]`. Stored bytes are neither cleared nor altered by reset or by a protection episode.
- R2: When the synchronised pins show `ceN`=0, `weN`=1 and `oeN`=0 and the block is active, `dqOe` is 1 and `dqOut` equals the byte at the synchronised address. Otherwise `dqOe` is 0, except for the hold described in R6.
- R3: A write window opens in the cycle in which both synchronised `ceN` and `weN` first read 0 together, which is the later of the two falling edges. It closes in the cycle in which either of them first reads 1 again, which is the earlier rising edge.
- R4: On close, the address and data that were present during the last cycle of the overlap are written.
- R5: For `REC_CYCLES` cycles after a commit, an attempt to open a window is ignored and sets `recoveryErr`. `recoveryErr` stays at 1 until reset.
- R6: If the synchronised `weN` falls while `ceN` and `oeN` are low, `dqOe` stays asserted for `OD_DELAY` cycles and then drops.
- R7: While `pwrFail` is 1, `protectMode` is 1 and `dqOe` is 0 in that same cycle. Any open window is aborted without a write.
- R8: Once protected, the block stays protected until a clock edge on which `pwrGood`=1 and `pwrFail`=0. `protectMode` then reads 0 from the next cycle on.
- R9: After reset, `protectMode`=0, `recoveryErr`=0 and `dqOe`=0.
- R10: A change on a control pin reaches the block's behaviour two clock cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 11 | Byte address |
| dqIn | input | 8 | Write data lane of the bus |
| dqOut | output | 8 | Read data lane of the bus (0 when not driven) |
| dqOe | output | 1 | Bus drive enable |
| pwrFail | input | 1 | Supply monitor: power failing |
| pwrGood | input | 1 | Supply monitor: supply recovered |
| protectMode | output | 1 | 1 while writes and pins are locked out |
| recoveryErr | output | 1 | Sticky flag for a recovery-interval violation |

## Verification
The close of a write window and the assertion of power-fail can land on the same clock edge. The bench provokes this by raising `weN` and then raising `pwrFail` exactly two cycles later, which is the cycle in which the close becomes visible after synchronisation. The abort must win: a read-back after recovery shows the old byte. A second pairing is a write strobe that starts while a read is being driven. Here the output hold of R6 and a new write window overlap, and the bench then checks both the delayed bus release and the byte that was stored.

// File: rtl/nvSramPkg.sv
package nvSramPkg;
  typedef struct packed {
    logic capture;  // latch address/data of the current overlap cycle
    logic commit;   // write the latched byte into the array
    logic drive;    // enable the bus drivers with array read data
  } strobe_t;

  typedef enum logic {
    MODE_ACTIVE  = 1'b0,
    MODE_PROTECT = 1'b1
  } mode_t;
endpackage

// File: rtl/nvSramSync.sv
module nvSramSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) stage[i] <= RST_VAL;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/nvSramCtrl.sv
module nvSramCtrl
  import nvSramPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 4,
  parameter int OD_DELAY    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    weN,
  input  logic    oeN,
  input  logic    pwrFail,
  input  logic    pwrGood,
  output strobe_t strobe,
  output logic    protectMode,
  output logic    recoveryErr
);
  localparam int REC_W = $clog2(REC_CYCLES + 1);
  localparam int OD_W  = $clog2(OD_DELAY + 1);

  logic [2:0] pinS;
  logic ceS, weS, oeS;

  nvSramSync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) uPinSync (
    .clk(clk), .rstN(rstN), .d({ceN, weN, oeN}), .q(pinS)
  );
  assign {ceS, weS, oeS} = pinS;

  mode_t mode;
  logic protect, act, actPrev, windowOpen, errSticky;
  logic openReq, closeEv;
  logic [REC_W-1:0] recCnt;
  logic [OD_W-1:0]  holdCnt;

  assign protect = (mode == MODE_PROTECT) || pwrFail;
  assign act     = !ceS && !weS;
  assign openReq = act && !actPrev;
  assign closeEv = !act && actPrev;

  always_comb begin
    strobe.capture = act && !protect;
    strobe.commit  = !protect && closeEv && windowOpen;
    strobe.drive   = !protect && !ceS && !oeS && (weS || holdCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_ACTIVE;
      actPrev    <= 1'b0;
      windowOpen <= 1'b0;
      errSticky  <= 1'b0;
      recCnt     <= '0;
      holdCnt    <= '0;
    end else begin
      actPrev <= act;

      if (pwrFail)      mode <= MODE_PROTECT;
      else if (pwrGood) mode <= MODE_ACTIVE;

      if (protect) windowOpen <= 1'b0;
      else if (openReq) begin
        if (recCnt != '0) errSticky  <= 1'b1;
        else              windowOpen <= 1'b1;
      end else if (closeEv) windowOpen <= 1'b0;

      if (strobe.commit)      recCnt <= REC_W'(REC_CYCLES);
      else if (recCnt != '0)  recCnt <= recCnt - 1'b1;

      if (weS)                holdCnt <= OD_W'(OD_DELAY);
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  assign protectMode = protect;
  assign recoveryErr = errSticky;
endmodule

// File: rtl/nvSramData.sv
module nvSramData
  import nvSramPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] dqOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrS, addrHold;
  logic [DATA_W-1:0] dataS, dataHold;
  logic [DATA_W-1:0] mem [DEPTH];

  nvSramSync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) uAddrSync (
    .clk(clk), .rstN(rstN), .d(addr), .q(addrS)
  );
  nvSramSync #(.W(DATA_W), .STAGES(SYNC_STAGES)) uDataSync (
    .clk(clk), .rstN(rstN), .d(dqIn), .q(dataS)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (strobe.capture) begin
      addrHold <= addrS;
      dataHold <= dataS;
    end
  end

  // array is deliberately outside reset so contents persist
  always_ff @(posedge clk) begin
    if (strobe.commit) mem[addrHold] <= dataHold;
  end

  assign dqOut = strobe.drive ? mem[addrS] : '0;
endmodule

// File: rtl/nvSramGuard.sv
module nvSramGuard
  import nvSramPkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REC_CYCLES  = 4,
  parameter int OD_DELAY    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic              pwrFail,
  input  logic              pwrGood,
  output logic              protectMode,
  output logic              recoveryErr
);
  strobe_t strobe;

  nvSramCtrl #(
    .SYNC_STAGES(SYNC_STAGES), .REC_CYCLES(REC_CYCLES), .OD_DELAY(OD_DELAY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .pwrFail(pwrFail), .pwrGood(pwrGood), .strobe(strobe),
    .protectMode(protectMode), .recoveryErr(recoveryErr)
  );

  nvSramData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .dqIn(dqIn),
    .strobe(strobe), .dqOut(dqOut)
  );

  assign dqOe = strobe.drive;
endmodule

// File: rtl/nvSramGuardChecker.sv
module nvSramGuardChecker (
  input logic clk,
  input logic rstN,
  input logic pwrFail,
  input logic pwrGood,
  input logic dqOe,
  input logic protectMode,
  input logic recoveryErr
);
  assert_fail_locks_R7: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |-> (protectMode && !dqOe));

  assert_protect_tristate_R7: assert property (@(posedge clk) disable iff (!rstN)
    protectMode |-> !dqOe);

  assert_stay_protected_R8: assert property (@(posedge clk) disable iff (!rstN)
    (protectMode && !pwrGood) |=> protectMode);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (protectMode && pwrGood && !pwrFail) |=> (protectMode == pwrFail));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    recoveryErr |=> recoveryErr);
endmodule

bind nvSramGuard nvSramGuardChecker chk (
  .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .pwrGood(pwrGood),
  .dqOe(dqOe), .protectMode(protectMode), .recoveryErr(recoveryErr)
);

// File: tb/nvSramGuard_test.sv
module nvSramGuard_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 4;
  localparam int OD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] dqIn = '0;
  logic [7:0] dqOut;
  logic dqOe, protectMode, recoveryErr;
  logic pwrFail = 1'b0, pwrGood = 1'b0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvSramGuard #(.REC_CYCLES(REC), .OD_DELAY(OD)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .pwrFail(pwrFail), .pwrGood(pwrGood),
    .protectMode(protectMode), .recoveryErr(recoveryErr)
  );

  // behavioural reference: pin history, counters, byte store
  logic [2:0] pinQ [$];
  logic [10:0] addrQ [$];
  logic [7:0] dataQ [$];
  bit [7:0] refMem [int];
  int refRec, refHold;
  bit refProt, refErr, refOpen, refBoth;
  logic [10:0] refAddrHold;
  logic [7:0] refDataHold;

  function automatic void check(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endfunction

  function automatic void refReset();
    pinQ = '{3'b111, 3'b111};
    addrQ = '{11'd0, 11'd0};
    dataQ = '{8'd0, 8'd0};
    refRec = 0; refHold = 0;
    refProt = 0; refErr = 0; refOpen = 0; refBoth = 0;
    refAddrHold = '0; refDataHold = '0;
  endfunction

  initial refReset();

  always @(posedge clk) begin
    if (!rstN) refReset();
    else begin
      logic [2:0] seen;
      bit both, locked, endWrite;
      seen = pinQ[0];
      both = !seen[2] && !seen[1];
      locked = refProt || pwrFail;
      endWrite = !locked && !both && refBoth && refOpen;
      if (endWrite) refMem[int'(refAddrHold)] = refDataHold;
      if (both && !locked) begin
        refAddrHold = addrQ[0];
        refDataHold = dataQ[0];
      end
      if (locked) refOpen = 0;
      else if (both && !refBoth) begin
        if (refRec > 0) refErr = 1;
        else refOpen = 1;
      end else if (!both && refBoth) refOpen = 0;
      if (endWrite) refRec = REC;
      else if (refRec > 0) refRec--;
      if (seen[1]) refHold = OD;
      else if (refHold > 0) refHold--;
      if (pwrFail) refProt = 1;
      else if (pwrGood) refProt = 0;
      refBoth = both;
      void'(pinQ.pop_front()); pinQ.push_back({ceN, weN, oeN});
      void'(addrQ.pop_front()); addrQ.push_back(addr);
      void'(dataQ.pop_front()); dataQ.push_back(dqIn);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [2:0] seen;
      bit locked, drv;
      seen = pinQ[0];
      locked = refProt || pwrFail;
      drv = !locked && !seen[2] && !seen[0] && (seen[1] || refHold > 0);
      check(dqOe == drv, "R2/R6/R7 dqOe", dqOe, drv);
      check(protectMode == locked, "R7/R8 protectMode", protectMode, locked);
      check(recoveryErr == refErr, "R5 recoveryErr", recoveryErr, refErr);
      if (drv && refMem.exists(int'(addrQ[0])))
        check(dqOut == refMem[int'(addrQ[0])], "R2 dqOut", dqOut, refMem[int'(addrQ[0])]);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeByte(logic [10:0] a, logic [7:0] d, bit weFirst, string tag);
    addr = a; dqIn = d;
    if (weFirst) begin weN = 0; tick(2); ceN = 0; end
    else begin ceN = 0; tick(2); weN = 0; end
    tick(3);
    if (weFirst) ceN = 1; else weN = 1;
    tick(2);
    ceN = 1; weN = 1;
    tick(REC + 4);
    check(recoveryErr == 0, tag, recoveryErr, 0);
  endtask

  task automatic readByte(logic [10:0] a, logic [7:0] expected, string tag);
    addr = a; ceN = 0; oeN = 0;
    tick(3);
    check(dqOe == 1, tag, dqOe, 1);
    check(dqOut == expected, tag, dqOut, expected);
    ceN = 1; oeN = 1;
    tick(3);
  endtask

  initial begin
    tick(3);
    check(dqOe == 0 && protectMode == 0 && recoveryErr == 0, "R9 reset state",
          {dqOe, protectMode, recoveryErr}, 0);
    rstN = 1;
    tick(2);

    writeByte(11'd5, 8'h3C, 0, "R3 ce-first write");
    // R10: read enable visible after two edges
    addr = 11'd5; ceN = 0; oeN = 0;
    tick(1);
    check(dqOe == 0, "R10 one cycle", dqOe, 0);
    tick(1);
    check(dqOe == 1 && dqOut == 8'h3C, "R10 two cycles R4", dqOut, 8'h3C);
    ceN = 1; oeN = 1; tick(3);

    writeByte(11'h7FF, 8'hA5, 1, "R3 we-first write");
    readByte(11'h7FF, 8'hA5, "R1 R3 top address");

    // R6 then R5: strobe during a driven read, then an early second write
    addr = 11'd5; dqIn = 8'h3C; ceN = 0; oeN = 0;
    tick(3);
    weN = 0;
    tick(2 + OD + 1);
    check(dqOe == 0, "R6 drivers released", dqOe, 0);
    weN = 1;
    tick(2);
    dqIn = 8'h11; weN = 0;
    tick(3);
    weN = 1; ceN = 1; oeN = 1;
    tick(8);
    check(recoveryErr == 1, "R5 violation flagged", recoveryErr, 1);
    readByte(11'd5, 8'h3C, "R5 early write ignored");

    // R7/R8: power-fail during an open window
    rstN = 0; tick(2); rstN = 1; tick(2);
    writeByte(11'd9, 8'h20, 0, "R4 setup");
    addr = 11'd9; dqIn = 8'h77; ceN = 0; weN = 0;
    tick(4);
    pwrFail = 1;
    tick(1);
    check(protectMode == 1 && dqOe == 0, "R7 lockout", protectMode, 1);
    weN = 1; ceN = 1;
    tick(3);
    pwrFail = 0;
    tick(3);
    check(protectMode == 1, "R8 still locked", protectMode, 1);
    dqIn = 8'h55; ceN = 0; weN = 0; tick(4); weN = 1; ceN = 1; tick(3);
    pwrGood = 1; tick(1); pwrGood = 0; tick(1);
    check(protectMode == 0, "R8 resumed", protectMode, 0);
    tick(REC);
    readByte(11'd9, 8'h20, "R7 aborted write");

    // concurrent: window close and power-fail on the same edge
    dqIn = 8'h44; ceN = 0; weN = 0;
    tick(4);
    weN = 1; tick(2);
    pwrFail = 1; tick(1);
    pwrFail = 0; ceN = 1;
    pwrGood = 1; tick(1); pwrGood = 0; tick(REC + 2);
    readByte(11'd9, 8'h20, "R7 close vs fail");

    // R1/R9: reset keeps contents, clears flags
    rstN = 0; tick(2);
    check(recoveryErr == 0 && protectMode == 0 && dqOe == 0, "R9 mid reset",
          {dqOe, protectMode, recoveryErr}, 0);
    rstN = 1; tick(2);
    readByte(11'd5, 8'h3C, "R1 retained");
    readByte(11'h7FF, 8'hA5, "R1 retained top");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule